// File: doc/BRIEF.md
# DMA Controller Global Control and Interrupt Block

This block is the shared register file that sits next to a set of DMA channels. It holds the controller-wide enable bit and two sticky flags. One flag records that some channel hit an address fault. The other records that some channel halted. The block also keeps one latched interrupt-pending bit per channel and merges those bits into a single interrupt line toward the processor.

Software also uses it to start channels and to gate their clocks. A write to the doorbell register sends a one-cycle descriptor-fetch start pulse to each channel whose bit is 1. A per-channel clock-enable vector can be loaded directly, or changed bit by bit through separate set and clear alias addresses. The clock enables are plain enable outputs and do not drive gating cells.

The CPU side is a simple 32-bit port: a write strobe, a byte address, write data and a read-data output that shows the addressed register combinationally. The asynchronous active-low reset goes through a two-stage synchronizer, so the block leaves reset on the second clock edge after the reset input rises. Register updates begin on the third edge.

Top module: `dma_gctl`

## Requirements
- R1: While reset is in effect, and until the synchronized reset releases, every register reads zero and `irq`, `fetch_start` and `clk_en` are all zero.
- R2: Offset 0x00 is global control. A write there stores bit 0 (controller enable) and bits 27 and 31 (stored mode bits with no effect on any output). All other bits of this register except 2 and 3 read zero.
- R3: Bit 3 of offset 0x00 is the halt flag and bit 2 is the address-fault flag. Each is set on the clock edge after any channel raises `ch_halt` or `ch_addr_err` respectively. A write to 0x00 with that bit at 0 clears the flag, and a write with the bit at 1 leaves it unchanged. A channel report in the same cycle as a clearing write wins, so the flag stays set.
- R4: Offset 0x04 holds one pending bit per channel, with bit i belonging to channel i. Bit i is set on the clock edge after a cycle in which `ch_irq_en[i]` is high and any of `ch_done[i]`, `ch_halt[i]` or `ch_addr_err[i]` is high. No pending bit is set while the channel's interrupt enable is low.
- R5: A write to 0x04 clears each pending bit written as 0 and keeps each bit written as 1. Writing a 1 never sets a bit that is clear. A channel event in the same cycle as a clearing write wins.
- R6: `irq` is high exactly when the controller enable (bit 0 of 0x00) is 1 and at least one pending bit is 1.
- R7: A write to offset 0x0C raises `fetch_start[i]` for exactly the one cycle after the write, for each bit i written as 1. A write to 0x08 produces no pulse. Offsets 0x08 and 0x0C both read zero.
- R8: Offset 0x10 holds the clock-enable vector, which drives `clk_en`. A write to 0x10 loads the vector. A write to 0x14 sets the bits written as 1, and a write to 0x18 clears the bits written as 1. Bits written as 0 through either alias are unchanged. Both aliases read zero.
- R9: Offset 0x1C is a per-channel programmable-channel mask. It stores the low NCH bits written to it and reads them back, and it affects no output.
- R10: A read of any byte address other than 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18 or 0x1C returns zero, including unaligned addresses. A write to such an address changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| ch_done | input | NCH | Per-channel transfer termination report |
| ch_halt | input | NCH | Per-channel halt report |
| ch_addr_err | input | NCH | Per-channel address-fault report |
| ch_irq_en | input | NCH | Per-channel interrupt enable |
| fetch_start | output | NCH | One-cycle descriptor-fetch start pulses |
| clk_en | output | NCH | Per-channel clock enables |
| irq | output | 1 | Combined interrupt |

## Verification
The stimulus begins with directed sequences. These cover a clearing write that lands in the same cycle as a channel event, so the bench can tell which of the two takes priority on the pending bits and on the sticky flags. They also apply events with the interrupt enable low, which separates "event seen" from "event gated". Doorbell writes go to both 0x08 and 0x0C, so the alias that pulses is told apart from the one that does not. Set and clear writes carry mixed bit patterns to show that zeros leave clock enables untouched. A long random phase follows over all offsets, including unaligned and unmapped ones, with sparse channel events. A behavioural model predicts every output and the read data of the addressed register on every clock, which exposes wrong priorities, stray bits and off-by-one pulse timing.

// File: rtl/dmagc_pkg.sv
package dmagc_pkg;
  localparam int unsigned DW = 32;

  // Software-visible byte offsets
  localparam logic [7:0] OFS_CTRL    = 8'h00;
  localparam logic [7:0] OFS_PEND    = 8'h04;
  localparam logic [7:0] OFS_BELL_RO = 8'h08;
  localparam logic [7:0] OFS_BELL    = 8'h0C;
  localparam logic [7:0] OFS_CKE     = 8'h10;
  localparam logic [7:0] OFS_CKE_SET = 8'h14;
  localparam logic [7:0] OFS_CKE_CLR = 8'h18;
  localparam logic [7:0] OFS_PMASK   = 8'h1C;

  // Global control bit positions
  localparam int unsigned B_EN    = 0;
  localparam int unsigned B_AERR  = 2;
  localparam int unsigned B_HALT  = 3;
  localparam int unsigned B_MODEA = 27;
  localparam int unsigned B_MODEB = 31;

  typedef struct packed {
    logic ctrl;
    logic pend;
    logic bell;
    logic cke_ld;
    logic cke_set;
    logic cke_clr;
    logic pmask;
  } wsel_t;
endpackage

// File: rtl/dmagc_rstsync.sv
module dmagc_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/dmagc_ctrl.sv
module dmagc_ctrl
  import dmagc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic          any_halt,
  input  logic          any_aerr,
  output logic          en,
  output logic [DW-1:0] ctrl_rd
);
  logic en_q, en_d;
  logic aerr_q, aerr_d;
  logic halt_q, halt_d;
  logic [1:0] mode_q, mode_d;
  logic upd;

  always_comb begin
    en_d   = en_q;
    mode_d = mode_q;
    aerr_d = aerr_q | any_aerr;
    halt_d = halt_q | any_halt;
    if (we) begin
      en_d   = wdata[B_EN];
      mode_d = {wdata[B_MODEB], wdata[B_MODEA]};
      aerr_d = (aerr_q & wdata[B_AERR]) | any_aerr;
      halt_d = (halt_q & wdata[B_HALT]) | any_halt;
    end
  end

  assign upd = we | any_halt | any_aerr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      aerr_q <= 1'b0;
      halt_q <= 1'b0;
      mode_q <= 2'b00;
    end else if (upd) begin
      en_q   <= en_d;
      aerr_q <= aerr_d;
      halt_q <= halt_d;
      mode_q <= mode_d;
    end
  end

  always_comb begin
    ctrl_rd          = '0;
    ctrl_rd[B_EN]    = en_q;
    ctrl_rd[B_AERR]  = aerr_q;
    ctrl_rd[B_HALT]  = halt_q;
    ctrl_rd[B_MODEA] = mode_q[0];
    ctrl_rd[B_MODEB] = mode_q[1];
  end

  assign en = en_q;

  // R3: a channel report always leaves the flag set
  a_r3_aerr_set: assert property (@(posedge clk) disable iff (!rst_n)
    any_aerr |=> aerr_q);
  a_r3_halt_set: assert property (@(posedge clk) disable iff (!rst_n)
    any_halt |=> halt_q);
  // R3: a flag only rises after a report
  a_r3_no_spont: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(aerr_q) || $rose(halt_q)) |-> $past(any_aerr || any_halt));
  // R3: a clearing write with no report drops the halt flag
  a_r3_halt_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !wdata[B_HALT] && !any_halt) |=> !halt_q);
endmodule

// File: rtl/dmagc_pend.sv
module dmagc_pend #(
  parameter int unsigned NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [NCH-1:0] wkeep,
  input  logic [NCH-1:0] set_v,
  output logic [NCH-1:0] pend
);
  logic [NCH-1:0] pend_q, pend_d;

  for (genvar i = 0; i < NCH; i++) begin : g_bit
    always_comb begin
      pend_d[i] = pend_q[i];
      if (we) pend_d[i] = pend_q[i] & wkeep[i];
      if (set_v[i]) pend_d[i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pend_q[i] <= 1'b0;
      else if (we || set_v[i])   pend_q[i] <= pend_d[i];
    end
  end

  assign pend = pend_q;

  // R4: every enabled event is latched
  a_r4_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (set_v != '0) |=> ((pend_q & $past(set_v)) == $past(set_v)));
  // R5: no bit rises without an event
  a_r5_no_spont: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(set_v)) == '0));
  // R5: bits written as 1 stay pending
  a_r5_keep_ones: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((pend_q & $past(pend_q & wkeep)) == $past(pend_q & wkeep)));
endmodule

// File: rtl/dmagc_chanbits.sv
module dmagc_chanbits #(
  parameter int unsigned NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bell_we,
  input  logic           cke_ld,
  input  logic           cke_set,
  input  logic           cke_clr,
  input  logic           pmask_we,
  input  logic [NCH-1:0] wbits,
  output logic [NCH-1:0] fetch,
  output logic [NCH-1:0] cke,
  output logic [NCH-1:0] pmask
);
  logic [NCH-1:0] fetch_q, fetch_d;
  logic [NCH-1:0] cke_q, cke_d;
  logic [NCH-1:0] pm_q;
  logic           cke_upd;

  assign cke_upd = cke_ld | cke_set | cke_clr;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_comb begin
      fetch_d[i] = bell_we & wbits[i];
      cke_d[i]   = cke_q[i];
      if (cke_ld)                    cke_d[i] = wbits[i];
      else if (cke_set && wbits[i])  cke_d[i] = 1'b1;
      else if (cke_clr && wbits[i])  cke_d[i] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fetch_q[i] <= 1'b0;
        cke_q[i]   <= 1'b0;
        pm_q[i]    <= 1'b0;
      end else begin
        fetch_q[i] <= fetch_d[i];
        if (cke_upd)  cke_q[i] <= cke_d[i];
        if (pmask_we) pm_q[i]  <= wbits[i];
      end
    end
  end

  assign fetch = fetch_q;
  assign cke   = cke_q;
  assign pmask = pm_q;

  // R7: a start pulse only follows a doorbell write
  a_r7_pulse_src: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_q != '0) |-> $past(bell_we));
  // R8: set alias turns on the addressed bits
  a_r8_set_on: assert property (@(posedge clk) disable iff (!rst_n)
    cke_set |=> ((cke_q & $past(wbits)) == $past(wbits)));
  // R8: clear alias turns off the addressed bits
  a_r8_clr_off: assert property (@(posedge clk) disable iff (!rst_n)
    cke_clr |=> ((cke_q & $past(wbits)) == '0));
endmodule

// File: rtl/dma_gctl.sv
module dma_gctl
  import dmagc_pkg::*;
#(
  parameter int unsigned NCH    = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [NCH-1:0]    ch_done,
  input  logic [NCH-1:0]    ch_halt,
  input  logic [NCH-1:0]    ch_addr_err,
  input  logic [NCH-1:0]    ch_irq_en,
  output logic [NCH-1:0]    fetch_start,
  output logic [NCH-1:0]    clk_en,
  output logic              irq
);
  localparam int unsigned PADW = DW - NCH;

  logic           rst_i_n;
  wsel_t          wsel;
  logic           en;
  logic [DW-1:0]  ctrl_rd;
  logic [NCH-1:0] pend, set_v, pmask;
  logic [NCH-1:0] wbits;

  dmagc_rstsync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_comb begin
    wsel.ctrl    = reg_we & hit(reg_addr, OFS_CTRL);
    wsel.pend    = reg_we & hit(reg_addr, OFS_PEND);
    wsel.bell    = reg_we & hit(reg_addr, OFS_BELL);
    wsel.cke_ld  = reg_we & hit(reg_addr, OFS_CKE);
    wsel.cke_set = reg_we & hit(reg_addr, OFS_CKE_SET);
    wsel.cke_clr = reg_we & hit(reg_addr, OFS_CKE_CLR);
    wsel.pmask   = reg_we & hit(reg_addr, OFS_PMASK);
  end

  assign wbits = reg_wdata[NCH-1:0];
  assign set_v = ch_irq_en & (ch_done | ch_halt | ch_addr_err);

  dmagc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_i_n), .we(wsel.ctrl), .wdata(reg_wdata),
    .any_halt(|ch_halt), .any_aerr(|ch_addr_err),
    .en(en), .ctrl_rd(ctrl_rd)
  );

  dmagc_pend #(.NCH(NCH)) u_pend (
    .clk(clk), .rst_n(rst_i_n), .we(wsel.pend), .wkeep(wbits),
    .set_v(set_v), .pend(pend)
  );

  dmagc_chanbits #(.NCH(NCH)) u_bits (
    .clk(clk), .rst_n(rst_i_n), .bell_we(wsel.bell),
    .cke_ld(wsel.cke_ld), .cke_set(wsel.cke_set), .cke_clr(wsel.cke_clr),
    .pmask_we(wsel.pmask), .wbits(wbits),
    .fetch(fetch_start), .cke(clk_en), .pmask(pmask)
  );

  always_comb begin
    reg_rdata = '0;
    if (hit(reg_addr, OFS_CTRL))       reg_rdata = ctrl_rd;
    else if (hit(reg_addr, OFS_PEND))  reg_rdata = {{PADW{1'b0}}, pend};
    else if (hit(reg_addr, OFS_CKE))   reg_rdata = {{PADW{1'b0}}, clk_en};
    else if (hit(reg_addr, OFS_PMASK)) reg_rdata = {{PADW{1'b0}}, pmask};
  end

  assign irq = en & (|pend);

  // R6: the interrupt line stays low while the controller is disabled
  a_r6_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_i_n)
    irq |-> ctrl_rd[B_EN]);
  // R1: nothing leaves the block while held in reset
  a_r1_quiet_reset: assert property (@(posedge clk)
    !rst_i_n |-> (fetch_start == '0 && clk_en == '0 && !irq));
endmodule

// File: tb/dma_gctl_tb.sv
module dma_gctl_tb_top;
  localparam int NCH = 8;
  localparam int AW  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NCH-1:0] ch_done = '0, ch_halt = '0, ch_addr_err = '0, ch_irq_en = '0;
  logic [NCH-1:0] fetch_start, clk_en;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dma_gctl #(.NCH(NCH), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_done(ch_done),
    .ch_halt(ch_halt), .ch_addr_err(ch_addr_err), .ch_irq_en(ch_irq_en),
    .fetch_start(fetch_start), .clk_en(clk_en), .irq(irq)
  );

  // Behavioural reference state
  bit        m_en = 0, m_aerr = 0, m_halt = 0, m_ma = 0, m_mb = 0;
  bit [7:0]  m_pend = 0, m_cke = 0, m_pm = 0, m_fetch = 0;
  int        m_sync = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_aerr = 0; m_halt = 0; m_ma = 0; m_mb = 0;
      m_pend = 0; m_cke = 0; m_pm = 0; m_fetch = 0; m_sync = 0;
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      bit wr0, wr4, wrc, wr10, wr14, wr18, wr1c;
      wr0  = reg_we && reg_addr == 8'h00;
      wr4  = reg_we && reg_addr == 8'h04;
      wrc  = reg_we && reg_addr == 8'h0C;
      wr10 = reg_we && reg_addr == 8'h10;
      wr14 = reg_we && reg_addr == 8'h14;
      wr18 = reg_we && reg_addr == 8'h18;
      wr1c = reg_we && reg_addr == 8'h1C;
      if (wr0) begin
        m_en = reg_wdata[0]; m_ma = reg_wdata[27]; m_mb = reg_wdata[31];
        if (!reg_wdata[2]) m_aerr = 0;
        if (!reg_wdata[3]) m_halt = 0;
      end
      if (ch_addr_err != 0) m_aerr = 1;
      if (ch_halt != 0) m_halt = 1;
      if (wr4) m_pend = m_pend & reg_wdata[7:0];
      m_pend = m_pend | (ch_irq_en & (ch_done | ch_halt | ch_addr_err));
      if (wr10) m_cke = reg_wdata[7:0];
      if (wr14) m_cke = m_cke | reg_wdata[7:0];
      if (wr18) m_cke = m_cke & ~reg_wdata[7:0];
      if (wr1c) m_pm = reg_wdata[7:0];
      m_fetch = wrc ? reg_wdata[7:0] : 8'h00;
    end
  end

  function automatic bit [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return {m_mb, 3'b0, m_ma, 23'b0, m_halt, m_aerr, 1'b0, m_en};
      8'h04: return {24'b0, m_pend};
      8'h10: return {24'b0, m_cke};
      8'h1C: return {24'b0, m_pm};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [7:0] a);
    case (a)
      8'h00: return "R2/R3 control";
      8'h04: return "R4/R5 pending";
      8'h08, 8'h0C: return "R7 doorbell readback";
      8'h10, 8'h14, 8'h18: return "R8 clock enable readback";
      8'h1C: return "R9 channel mask";
      default: return "R10 unmapped";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cycles, act, exp);
    end
  endtask

  // Compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      if (m_sync < 2) begin
        chk("R1 reset clk_en", 32'(clk_en), 32'h0);
        chk("R1 reset irq", 32'(irq), 32'h0);
        chk("R1 reset fetch", 32'(fetch_start), 32'h0);
        chk("R1 reset read", reg_rdata, 32'h0);
      end else begin
        chk("R6 irq", 32'(irq), 32'(m_en && (m_pend != 0)));
        chk("R7 fetch_start", 32'(fetch_start), 32'(m_fetch));
        chk("R8 clk_en", 32'(clk_en), 32'(m_cke));
        chk(rd_tag(reg_addr), reg_rdata, m_read(reg_addr));
      end
    end
  end

  task automatic drive(input bit we, input logic [7:0] a, input logic [31:0] d,
                       input logic [7:0] dn, input logic [7:0] hl,
                       input logic [7:0] ae, input logic [7:0] ie);
    @(posedge clk); #2;
    reg_we = we; reg_addr = a; reg_wdata = d;
    ch_done = dn; ch_halt = hl; ch_addr_err = ae; ch_irq_en = ie;
  endtask

  task automatic rd(input logic [7:0] a);
    drive(0, a, 32'h0, 8'h0, 8'h0, 8'h0, 8'hFF);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired at cycle %0d: actual=running expected=done", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] ofs [11] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14,
                            8'h18, 8'h1C, 8'h20, 8'h3C, 8'h05};
    #1 rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) rd(8'h00);
    // R2: enable plus mode bits plus junk
    drive(1, 8'h00, 32'hFFFF_FFFF, 0, 0, 0, 0);
    rd(8'h00);
    // R4: event with enable low is ignored, then enabled events latch
    drive(0, 8'h04, 0, 8'h01, 0, 0, 8'h00);
    rd(8'h04);
    drive(0, 8'h04, 0, 8'h05, 8'h10, 8'h80, 8'hFF);
    rd(8'h04);
    // R5: keep bit 0 and bit 4, clear the rest, while channel 1 reports
    drive(1, 8'h04, 32'h0000_0011, 8'h02, 0, 0, 8'hFF);
    rd(8'h04);
    // R5: writing ones does not set clear bits
    drive(1, 8'h04, 32'h0000_00FF, 0, 0, 0, 8'hFF);
    rd(8'h04);
    // R3: clear flags while a halt arrives; halt wins, address flag clears
    drive(1, 8'h00, 32'h0000_0001, 0, 8'h04, 0, 8'h00);
    rd(8'h00);
    drive(1, 8'h00, 32'h0000_000D, 0, 0, 0, 8'h00);
    rd(8'h00);
    // R6: disable the controller with pending bits outstanding
    drive(1, 8'h00, 32'h0, 0, 0, 0, 8'h00);
    rd(8'h00);
    drive(1, 8'h04, 32'h0, 0, 0, 0, 8'h00);
    // R7: both doorbell offsets
    drive(1, 8'h08, 32'h0000_00FF, 0, 0, 0, 0);
    drive(1, 8'h0C, 32'h0000_00A5, 0, 0, 0, 0);
    drive(1, 8'h0C, 32'h0000_005A, 0, 0, 0, 0);
    rd(8'h0C);
    // R8: load, set, clear with mixed patterns
    drive(1, 8'h10, 32'h0000_0033, 0, 0, 0, 0);
    drive(1, 8'h14, 32'h0000_0081, 0, 0, 0, 0);
    drive(1, 8'h18, 32'h0000_0012, 0, 0, 0, 0);
    rd(8'h14);
    rd(8'h10);
    // R9 and R10
    drive(1, 8'h1C, 32'hFFFF_FF3C, 0, 0, 0, 0);
    rd(8'h1C);
    drive(1, 8'h20, 32'hFFFF_FFFF, 0, 0, 0, 0);
    drive(1, 8'h11, 32'hFFFF_FFFF, 0, 0, 0, 0);
    rd(8'h11);
    rd(8'h10);
    // Random phase
    for (int k = 0; k < 4000; k++) begin
      logic [7:0] dn, hl, ae;
      dn = ($urandom % 4 == 0) ? 8'($urandom) : 8'h0;
      hl = ($urandom % 8 == 0) ? 8'(1 << ($urandom % 8)) : 8'h0;
      ae = ($urandom % 8 == 0) ? 8'(1 << ($urandom % 8)) : 8'h0;
      drive(($urandom % 2) == 1, ofs[$urandom % 11], $urandom, dn, hl, ae, 8'($urandom));
    end
    rd(8'h00);
    rd(8'h00);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule